// File: doc/BRIEF.md
# Timed DDS Tone Generator

This block is a direct digital synthesis tone source that runs from a sample-rate tick enable. On each tick while it runs, a phase accumulator advances by a programmable step word. The top bits of the accumulator address an internal signed waveform ROM. The sample is scaled by an 8-bit amplitude and offset to mid-scale. The registered result is a code for a downstream PWM comparator or DAC. The output frequency is step × tick rate / 2^ACC_W.

A start pulse captures the step word, the amplitude, a burst length and a time-limited flag, and sets the running state. A stop pulse clears the running state at once. Software can load the phase directly or shift it by a signed offset, both expressed as accumulator words. In time-limited mode the block counts running ticks. When the count is used up, it clears the phase, stops and parks the output at a build-time idle level, either mid-scale or zero.

Top module: `tone_synth`

## Requirements
- R1: After reset, running_out is low and level_out holds the idle level.
- R2: On a tick while running, with no phase write, the accumulator becomes accumulator + step modulo 2^24. Start and stop are both low for this rule.
- R3: The ROM index is accumulator bits [23:16]. With h = index mod 128 and m = floor(h·(127−h)/32), the entry is +m for index < 128 and −m otherwise.
- R4: With amplitude 0, a running tick yields exactly mid-scale, 128.
- R5: With amplitude 255, a running tick yields sample + 128.
- R6: With amplitude 1 to 254, a running tick yields floor(sample·amplitude/256) + 128.
- R7: level_out changes only at the clock edge that samples a tick or a stop, one cycle after the input. Cycles with neither leave it unchanged.
- R8: A start pulse loads step, amplitude, burst length and time-limited flag, and sets running_out on the next edge. In that cycle a tick has no effect and the phase is kept.
- R9: A stop pulse clears running_out and drives the idle level on the next edge. Stop wins over start in the same cycle.
- R10: In time-limited mode with burst length L, the first L running ticks produce samples. The next tick clears running_out, zeroes the accumulator and drives the idle level.
- R11: The idle level is 128 when IDLE_MID is 1 and 0 when IDLE_MID is 0. It is driven on every tick while not running.
- R12: Phase-set loads the accumulator with the phase word, and phase-add adds the phase word modulo 2^24. Set wins over add. On a non-ending running tick, a phase write replaces the step addition, and the sample comes from the written phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Sample-rate enable |
| start | input | 1 | Capture configuration and run |
| stop | input | 1 | Halt and go idle |
| timed_in | input | 1 | Time-limited burst select, captured at start |
| step_in | input | 24 | Frequency step word, captured at start |
| amp_in | input | 8 | Amplitude, captured at start |
| burst_in | input | 16 | Burst length in ticks, captured at start |
| phase_set | input | 1 | Load accumulator with phase_word |
| phase_add | input | 1 | Add phase_word to accumulator |
| phase_word | input | 24 | Phase value or offset |
| level_out | output | 8 | Registered output code |
| running_out | output | 1 | Generator running |

## Verification
Each result appears at the first clock edge after its stimulus: a sample or idle code after a tick, the idle code after a stop, and running_out after a start, stop or ending tick. The bench drives each input set at a falling edge and advances its reference model in the same step. At the next falling edge it compares level_out and running_out, so every check sits one edge after its stimulus. Internal reset release takes two edges, and the bench waits several cycles before its first stimulus.

// File: rtl/tone_pkg.sv
package tone_pkg;

  localparam int TBL_AW   = 8;
  localparam int SAMPLE_W = 8;

  // Parabolic approximation of one sine period over 2^TBL_AW entries
  function automatic logic signed [SAMPLE_W-1:0] wave_entry(input int k);
    int h;
    int m;
    int v;
    h = k % 128;
    m = (h * (127 - h)) / 32;
    v = (k >= 128) ? -m : m;
    return v[SAMPLE_W-1:0];
  endfunction

endpackage

// File: rtl/tone_rom.sv
module tone_rom
  import tone_pkg::*;
(
  input  logic [TBL_AW-1:0]          idx,
  output logic signed [SAMPLE_W-1:0] sample
);

  localparam int DEPTH = 1 << TBL_AW;

  logic signed [SAMPLE_W-1:0] rom [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    assign rom[k] = wave_entry(k);
  end

  assign sample = rom[idx];

endmodule

// File: rtl/tone_scale.sv
module tone_scale
  import tone_pkg::*;
#(
  parameter int AMP_W = 8,
  parameter int OUT_W = 8
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic [AMP_W-1:0]           amp,
  output logic [OUT_W-1:0]           code
);

  localparam int SH      = SAMPLE_W - OUT_W;
  localparam int PW      = SAMPLE_W + AMP_W + 2;
  localparam int MID     = 1 << (OUT_W - 1);
  localparam int AMP_MAX = (1 << AMP_W) - 1;

  logic signed [PW-1:0] samp_x;
  logic signed [PW-1:0] amp_x;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] scaled;
  logic signed [PW-1:0] sum;

  always_comb begin
    samp_x = PW'(sample);
    amp_x  = $signed(PW'(amp));
    prod   = samp_x * amp_x;
    if (amp == '0) begin
      scaled = '0;
    end else if (amp == AMP_W'(AMP_MAX)) begin
      scaled = samp_x >>> SH;
    end else begin
      scaled = prod >>> (AMP_W + SH);
    end
    sum  = scaled + PW'(MID);
    code = OUT_W'(sum);
  end

endmodule

// File: rtl/tone_phase.sv
module tone_phase #(
  parameter int ACC_W = 24,
  parameter int AMP_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic             timed_in,
  input  logic [ACC_W-1:0] step_in,
  input  logic [AMP_W-1:0] amp_in,
  input  logic [CNT_W-1:0] burst_in,
  input  logic             phase_set,
  input  logic             phase_add,
  input  logic [ACC_W-1:0] phase_word,
  output logic [ACC_W-1:0] acc_d,
  output logic [AMP_W-1:0] amp_q,
  output logic             run_q,
  output logic             shape_en,
  output logic             idle_en
);

  logic [ACC_W-1:0] acc_q, step_q, step_d, phase_val;
  logic [AMP_W-1:0] amp_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             timed_q, timed_d, run_d, phase_wr;

  always_comb begin
    phase_wr  = phase_set | phase_add;
    phase_val = phase_set ? phase_word : (acc_q + phase_word);
    acc_d     = acc_q;
    run_d     = run_q;
    step_d    = step_q;
    amp_d     = amp_q;
    rem_d     = rem_q;
    timed_d   = timed_q;
    shape_en  = 1'b0;
    idle_en   = 1'b0;
    if (stop) begin
      run_d   = 1'b0;
      idle_en = 1'b1;
      if (phase_wr) acc_d = phase_val;
    end else if (start) begin
      run_d   = 1'b1;
      step_d  = step_in;
      amp_d   = amp_in;
      rem_d   = burst_in;
      timed_d = timed_in;
      if (phase_wr) acc_d = phase_val;
    end else if (tick && run_q) begin
      if (timed_q && (rem_q == '0)) begin
        run_d   = 1'b0;
        acc_d   = '0;
        idle_en = 1'b1;
      end else begin
        acc_d    = phase_wr ? phase_val : (acc_q + step_q);
        shape_en = 1'b1;
        if (timed_q) rem_d = rem_q - 1'b1;
      end
    end else begin
      if (tick) idle_en = 1'b1;
      if (phase_wr) acc_d = phase_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      step_q  <= '0;
      amp_q   <= '0;
      rem_q   <= '0;
      timed_q <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      acc_q   <= acc_d;
      step_q  <= step_d;
      amp_q   <= amp_d;
      rem_q   <= rem_d;
      timed_q <= timed_d;
      run_q   <= run_d;
    end
  end

endmodule

// File: rtl/tone_synth.sv
module tone_synth
  import tone_pkg::*;
#(
  parameter int ACC_W    = 24,
  parameter int AMP_W    = 8,
  parameter int CNT_W    = 16,
  parameter int OUT_W    = 8,
  parameter bit IDLE_MID = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic             timed_in,
  input  logic [ACC_W-1:0] step_in,
  input  logic [AMP_W-1:0] amp_in,
  input  logic [CNT_W-1:0] burst_in,
  input  logic             phase_set,
  input  logic             phase_add,
  input  logic [ACC_W-1:0] phase_word,
  output logic [OUT_W-1:0] level_out,
  output logic             running_out
);

  localparam logic [OUT_W-1:0] MID_CODE  = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] IDLE_CODE = IDLE_MID ? MID_CODE : '0;

  logic [1:0]               rst_sync;
  logic                     rst_int_n;
  logic [ACC_W-1:0]         acc_d;
  logic [AMP_W-1:0]         amp_q;
  logic                     run_q, shape_en, idle_en;
  logic signed [SAMPLE_W-1:0] sample;
  logic [OUT_W-1:0]         code, level_q, level_d;

  // Reset asserts at once, releases after two edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  tone_phase #(.ACC_W(ACC_W), .AMP_W(AMP_W), .CNT_W(CNT_W)) phase_i (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .start(start), .stop(stop),
    .timed_in(timed_in), .step_in(step_in), .amp_in(amp_in),
    .burst_in(burst_in), .phase_set(phase_set), .phase_add(phase_add),
    .phase_word(phase_word), .acc_d(acc_d), .amp_q(amp_q), .run_q(run_q),
    .shape_en(shape_en), .idle_en(idle_en)
  );

  tone_rom rom_i (
    .idx(acc_d[ACC_W-1 -: TBL_AW]),
    .sample(sample)
  );

  tone_scale #(.AMP_W(AMP_W), .OUT_W(OUT_W)) scale_i (
    .sample(sample), .amp(amp_q), .code(code)
  );

  always_comb begin
    level_d = level_q;
    if (idle_en)       level_d = IDLE_CODE;
    else if (shape_en) level_d = code;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) level_q <= IDLE_CODE;
    else            level_q <= level_d;
  end

  assign level_out   = level_q;
  assign running_out = run_q;

endmodule

// File: rtl/tone_synth_chk.sv
module tone_synth_chk #(
  parameter int OUT_W    = 8,
  parameter bit IDLE_MID = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             start,
  input logic             stop,
  input logic [OUT_W-1:0] level_out,
  input logic             running_out
);

  localparam logic [OUT_W-1:0] MID_CODE  = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] IDLE_CODE = IDLE_MID ? MID_CODE : '0;

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> (!running_out && level_out == IDLE_CODE)); // R9

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !stop) |=> $stable(level_out)); // R7

  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !stop) |=> running_out); // R8

  AST_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !running_out && !start && !stop) |=> level_out == IDLE_CODE); // R11

  AST_RUN_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running_out) |-> $past(stop || tick)); // R10

endmodule

bind tone_synth tone_synth_chk #(.OUT_W(OUT_W), .IDLE_MID(IDLE_MID)) chk_i (
  .clk(clk), .rst_n(rst_int_n), .tick(tick), .start(start), .stop(stop),
  .level_out(level_out), .running_out(running_out)
);

// File: tb/tone_synth_tb.sv
module tone_synth_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 0, start = 0, stop = 0, timed_in = 0;
  logic        phase_set = 0, phase_add = 0;
  logic [23:0] step_in = '0, phase_word = '0;
  logic [7:0]  amp_in = '0;
  logic [15:0] burst_in = '0;
  logic [7:0]  level_out, level_z;
  logic        running_out, running_z;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // Reference state
  logic [23:0] m_acc, m_step;
  int          m_amp;
  int          m_rem;
  bit          m_timed, m_run, m_idle;
  int          m_lvl;
  string       m_tag;

  always #10 clk = ~clk;

  tone_synth dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .stop(stop),
    .timed_in(timed_in), .step_in(step_in), .amp_in(amp_in),
    .burst_in(burst_in), .phase_set(phase_set), .phase_add(phase_add),
    .phase_word(phase_word), .level_out(level_out), .running_out(running_out)
  );

  tone_synth #(.IDLE_MID(1'b0)) dut_z_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .stop(stop),
    .timed_in(timed_in), .step_in(step_in), .amp_in(amp_in),
    .burst_in(burst_in), .phase_set(phase_set), .phase_add(phase_add),
    .phase_word(phase_word), .level_out(level_z), .running_out(running_z)
  );

  function automatic int ref_sample(input logic [23:0] acc);
    int idx, h, m;
    idx = int'(acc[23:16]);
    h = idx % 128;
    m = (h * (127 - h)) / 32;
    return (idx < 128) ? m : -m;
  endfunction

  function automatic int ref_level(input logic [23:0] acc, input int amp);
    int s;
    s = ref_sample(acc);
    if (amp == 0)   return 128;
    if (amp == 255) return s + 128;
    return int'($floor(real'(s * amp) / 256.0)) + 128;
  endfunction

  function automatic string amp_tag(input int amp);
    if (amp == 0)   return "R4";
    if (amp == 255) return "R5";
    return "R6";
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    check({m_tag, " level"}, int'(level_out), m_lvl);
    check({m_tag, " running"}, int'(running_out), int'(m_run));
    check({m_tag, " R11 idle-zero level"}, int'(level_z), m_idle ? 0 : m_lvl);
    check({m_tag, " running (zero idle)"}, int'(running_z), int'(m_run));
  endtask

  // Drive one cycle of inputs, advance the model, check at the next falling edge
  task automatic cyc(input bit tk, input bit st, input bit sp, input bit tm,
                     input bit ps, input bit pa, input logic [23:0] stp,
                     input logic [23:0] pw, input int am, input int bl);
    logic [23:0] pv;
    bit pwr;
    tick = tk; start = st; stop = sp; timed_in = tm;
    phase_set = ps; phase_add = pa; step_in = stp; phase_word = pw;
    amp_in = am[7:0]; burst_in = bl[15:0];
    pwr = ps | pa;
    pv  = ps ? pw : (m_acc + pw);
    m_tag = "R7";
    if (sp) begin
      m_run = 0; m_lvl = 128; m_idle = 1; m_tag = "R9";
      if (pwr) m_acc = pv;
    end else if (st) begin
      m_run = 1; m_step = stp; m_amp = am; m_rem = bl; m_timed = tm;
      m_tag = "R8";
      if (pwr) m_acc = pv;
    end else if (tk && m_run) begin
      if (m_timed && m_rem == 0) begin
        m_run = 0; m_acc = '0; m_lvl = 128; m_idle = 1; m_tag = "R10";
      end else begin
        m_acc = pwr ? pv : (m_acc + m_step);
        m_lvl = ref_level(m_acc, m_amp); m_idle = 0;
        m_tag = pwr ? "R12" : {"R2 R3 ", amp_tag(m_amp)};
        if (m_timed) m_rem--;
      end
    end else begin
      if (tk) begin m_lvl = 128; m_idle = 1; m_tag = "R11"; end
      if (pwr) m_acc = pv;
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, '0, '0, 0, 0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    m_acc = '0; m_step = '0; m_amp = 0; m_rem = 0; m_timed = 0;
    m_run = 0; m_idle = 1; m_lvl = 128; m_tag = "R1";
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare_all(); // R1 reset state

    // R5 full amplitude sweep of samples
    cyc(0, 1, 0, 0, 0, 0, 24'h010000, '0, 255, 0);
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, 0, 0, '0, '0, 0, 0);
    idle_cycles(2); // R7 no tick, output holds
    // R12 phase set with tick wins over step, then add, then set beats add
    cyc(1, 0, 0, 0, 1, 0, '0, 24'h400000, 0, 0);
    cyc(1, 0, 0, 0, 0, 1, '0, 24'hE00000, 0, 0);
    cyc(0, 0, 0, 0, 1, 1, '0, 24'hC80000, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, '0, '0, 0, 0);
    // R4 zero amplitude
    cyc(0, 1, 0, 0, 0, 0, 24'h033333, '0, 0, 0);
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0, 0, '0, '0, 0, 0);
    // R6 partial amplitude, R8 start with tick ignores tick
    cyc(1, 1, 0, 0, 0, 0, 24'h0A0000, '0, 100, 0);
    for (int i = 0; i < 30; i++) cyc(1, 0, 0, 0, 0, 0, '0, '0, 0, 0);
    // R10 zero-length burst ends on first tick
    cyc(0, 1, 0, 1, 0, 0, 24'h050000, '0, 255, 0);
    cyc(1, 0, 0, 0, 0, 0, '0, '0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0, '0, '0, 0, 0); // R11 idle tick
    // R10 burst of three
    cyc(0, 1, 0, 1, 0, 0, 24'h050000, '0, 200, 3);
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0, 0, '0, '0, 0, 0);
    // R9 stop beats start, then stop while running
    cyc(0, 1, 1, 0, 0, 0, 24'h010000, '0, 255, 0);
    cyc(0, 1, 0, 0, 0, 0, 24'h010000, '0, 255, 0);
    cyc(1, 0, 0, 0, 0, 0, '0, '0, 0, 0);
    cyc(1, 0, 1, 0, 0, 0, '0, '0, 0, 0);

    // Constrained random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit tk, st, sp, tm, ps, pa;
      r  = int'($urandom_range(0, 99));
      tk = ($urandom_range(0, 2) != 0);
      st = (r < 4);
      sp = (r >= 4 && r < 6);
      tm = ($urandom_range(0, 1) == 1);
      ps = ($urandom_range(0, 29) == 0);
      pa = ($urandom_range(0, 29) == 0);
      cyc(tk, st, sp, tm, ps, pa, 24'($urandom()), 24'($urandom()),
          (r % 5 == 0) ? 0 : (r % 5 == 1) ? 255 : int'($urandom_range(0, 255)),
          int'($urandom_range(0, 40)));
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule